// File: doc/BRIEF.md
# Modular Converter Arm Cell Evaluator

This block evaluates every switching cell of one converter arm once per fixed simulation step, for a real-time plant model. Each cell has an upper and a lower gate input and a stored capacitor voltage. At the first cycle of a step the block samples the arm current and the gate patterns. A single shared pipeline then visits the cells one per cycle. For each cell it picks one of six cases from the gate pair and the sign of the current. The case decides whether the cell adds its capacitor voltage to the arm voltage and whether its capacitor integrates the sampled current.

The integration is forward Euler: `Vc_next = Vc + ((I * K) >>> FRAC)`. Here `K` is the programmable `dt/C` constant in signed fixed point with FRAC fractional bits, and `>>>` floors. A cell that conducts adds the capacitor voltage it held at the start of the step. At the end of each step the block publishes the arm voltage, a per-cell high-impedance mask and a fault flag. A slower host solver reads a second output, the arm voltage averaged over a fixed number of steps.

Top module: `mmc_arm_eval`

## Requirements
- R1: Cell i with gate_hi_i[i]=1 and gate_lo_i[i]=0 (inserted) adds its start-of-step capacitor voltage to arm_volt_o, and its capacitor becomes Vc + ((I*K) >>> 12).
- R2: Cell i with gate_hi_i[i]=0 and gate_lo_i[i]=1 (bypassed) adds 0, and its capacitor is held.
- R3: With both gates 0 and arm current > 0, the cell adds its capacitor voltage and integrates the current as in R1.
- R4: With both gates 0 and arm current < 0, the cell adds 0, and its capacitor is held.
- R5: With both gates 0 and arm current exactly 0, the cell adds 0, its capacitor is held, and hiz_o[i] is 1 for that step.
- R6: With both gates 1, the cell adds 0, its capacitor is held, and fault_o is 1 for that step.
- R7: Current, K and gates are sampled only on the first cycle of a step. Later changes within the step have no effect on its results or on any capacitor.
- R8: A step lasts STEP_CYCLES (25) cycles. arm_volt_o, hiz_o and fault_o change only on the last edge of a step, and step_done_o is a one-cycle pulse that marks that edge.
- R9: On every AVG_STEPS-th (100th) completed step, avg_volt_o becomes the sum of those steps' arm voltages divided by AVG_STEPS, truncated toward zero. avg_valid_o pulses together with step_done_o, and avg_volt_o is otherwise held.
- R10: After reset, every capacitor holds VC_INIT (1000), and all outputs are 0.
- R11: While run_i is 0 between steps, no step starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Allows a new step to start |
| dt_over_c_i | input | KW | Signed dt/C constant, FRAC fractional bits |
| arm_cur_i | input | IW | Signed arm current; positive charges the cells |
| gate_hi_i | input | N_CELLS | Upper gate per cell, bit i = cell i |
| gate_lo_i | input | N_CELLS | Lower gate per cell, bit i = cell i |
| arm_volt_o | output | AW | Signed sum of the conducting cells' voltages for the last step |
| hiz_o | output | N_CELLS | Cells in the high-impedance case in the last step |
| fault_o | output | 1 | Some cell had both gates on in the last step |
| step_done_o | output | 1 | One-cycle pulse when the step results update |
| avg_volt_o | output | AW | Arm voltage averaged over AVG_STEPS steps |
| avg_valid_o | output | 1 | Pulse when avg_volt_o updates |

## Verification
Directed steps drive every cell with the same case: inserted, bypassed, both gates off with positive, negative and zero current, and both gates on. An all-inserted step that follows reveals whether the earlier cases charged or held the capacitors. A sweep then rotates the four gate pairs across the cells against a rotating current sign and magnitude, so each step mixes conducting, held and integrating cells, and an error in one cell's case or index shows as a wrong sum. In every step the current, K and gates are corrupted a few cycles after sampling, which tells a design that samples once from one that reads the live inputs. The running sum of the sweep is checked against the averaged output.

// File: rtl/mmc_arm_pkg.sv
package mmc_arm_pkg;
  typedef enum logic [2:0] {
    CM_BYPASS,
    CM_INSERT,
    CM_DIODE_ON,
    CM_DIODE_OFF,
    CM_FLOAT,
    CM_SHORT
  } cell_mode_e;

  function automatic cell_mode_e cell_mode_f(logic hi, logic lo, logic cur_pos, logic cur_zero);
    cell_mode_e m;
    unique case ({hi, lo})
      2'b10:   m = CM_INSERT;
      2'b01:   m = CM_BYPASS;
      2'b11:   m = CM_SHORT;
      default: m = cur_zero ? CM_FLOAT : (cur_pos ? CM_DIODE_ON : CM_DIODE_OFF);
    endcase
    return m;
  endfunction
endpackage

// File: rtl/mmc_step_seq.sv
module mmc_step_seq #(
  parameter int STEP_CYCLES = 25,
  parameter int N_CELLS     = 10,
  parameter int IDXW        = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  output logic            start_o,
  output logic            issue_o,
  output logic [IDXW-1:0] idx_o,
  output logic            last_o
);
  localparam int CW = $clog2(STEP_CYCLES);

  logic [CW-1:0] cyc_q;

  assign start_o = run_i && (cyc_q == '0);
  assign last_o  = (cyc_q == CW'(STEP_CYCLES - 1));
  assign issue_o = (cyc_q != '0) && (cyc_q <= CW'(N_CELLS));
  assign idx_o   = IDXW'(cyc_q - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cyc_q <= '0;
    else if (start_o)         cyc_q <= CW'(1);
    else if (last_o)          cyc_q <= '0;
    else if (cyc_q != '0)     cyc_q <= cyc_q + CW'(1);
  end
endmodule

// File: rtl/mmc_cell_decode.sv
module mmc_cell_decode
  import mmc_arm_pkg::*;
#(
  parameter int N_CELLS = 10,
  parameter int IDXW    = 4
) (
  input  logic [N_CELLS-1:0] hi_i,
  input  logic [N_CELLS-1:0] lo_i,
  input  logic               cur_pos_i,
  input  logic               cur_zero_i,
  input  logic [IDXW-1:0]    idx_i,
  output cell_mode_e         mode_o
);
  assign mode_o = cell_mode_f(hi_i[idx_i], lo_i[idx_i], cur_pos_i, cur_zero_i);
endmodule

// File: rtl/mmc_cap_pipe.sv
module mmc_cap_pipe
  import mmc_arm_pkg::*;
#(
  parameter int N_CELLS = 10,
  parameter int VW      = 24,
  parameter int AW      = 28,
  parameter int IDXW    = 4,
  parameter int VC_INIT = 1000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 issue_i,
  input  logic [IDXW-1:0]      idx_i,
  input  cell_mode_e           mode_i,
  input  logic signed [VW-1:0] delta_i,
  output logic signed [AW-1:0] acc_o,
  output logic [N_CELLS-1:0]   hiz_o,
  output logic                 fault_o
);
  logic signed [VW-1:0] vc_q [N_CELLS];
  logic                 a_vld_q;
  logic [IDXW-1:0]      a_idx_q;
  cell_mode_e           a_mode_q;
  logic signed [VW-1:0] a_vc_q;

  // stage A: fetch capacitor, stage B: integrate, write back, accumulate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_vld_q  <= 1'b0;
      a_idx_q  <= '0;
      a_mode_q <= CM_BYPASS;
      a_vc_q   <= '0;
      acc_o    <= '0;
      hiz_o    <= '0;
      fault_o  <= 1'b0;
      for (int i = 0; i < N_CELLS; i++) vc_q[i] <= VW'(VC_INIT);
    end else begin
      a_vld_q <= issue_i;
      if (issue_i) begin
        a_idx_q  <= idx_i;
        a_mode_q <= mode_i;
        a_vc_q   <= vc_q[idx_i];
      end
      if (start_i) begin
        acc_o   <= '0;
        hiz_o   <= '0;
        fault_o <= 1'b0;
      end else if (a_vld_q) begin
        unique case (a_mode_q)
          CM_INSERT, CM_DIODE_ON: begin
            vc_q[a_idx_q] <= a_vc_q + delta_i;
            acc_o         <= acc_o + AW'(a_vc_q);
          end
          CM_FLOAT: hiz_o[a_idx_q] <= 1'b1;
          CM_SHORT: fault_o <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mmc_arm_avg.sv
module mmc_arm_avg #(
  parameter int AW        = 28,
  parameter int AVG_STEPS = 100
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic signed [AW-1:0] val_i,
  output logic signed [AW-1:0] avg_o,
  output logic                 avg_valid_o
);
  localparam int NW = $clog2(AVG_STEPS + 1);
  localparam int SW = AW + NW + 1;
  localparam logic signed [SW-1:0] AVG_DIV = SW'(AVG_STEPS);

  logic [NW-1:0]        cnt_q;
  logic signed [SW-1:0] sum_q;
  logic signed [SW-1:0] sum_nxt;
  logic signed [SW-1:0] quot;

  assign sum_nxt = sum_q + SW'(val_i);
  assign quot    = sum_nxt / AVG_DIV;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      sum_q       <= '0;
      avg_o       <= '0;
      avg_valid_o <= 1'b0;
    end else begin
      avg_valid_o <= 1'b0;
      if (tick_i) begin
        if (cnt_q == NW'(AVG_STEPS - 1)) begin
          avg_o       <= AW'(quot);
          avg_valid_o <= 1'b1;
          sum_q       <= '0;
          cnt_q       <= '0;
        end else begin
          sum_q <= sum_nxt;
          cnt_q <= cnt_q + NW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mmc_arm_eval.sv
module mmc_arm_eval
  import mmc_arm_pkg::*;
#(
  parameter int N_CELLS     = 10,
  parameter int STEP_CYCLES = 25,
  parameter int AVG_STEPS   = 100,
  parameter int IW          = 16,
  parameter int KW          = 16,
  parameter int FRAC        = 12,
  parameter int VW          = 24,
  parameter int VC_INIT     = 1000,
  localparam int AW         = VW + $clog2(N_CELLS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [KW-1:0]      dt_over_c_i,
  input  logic [IW-1:0]      arm_cur_i,
  input  logic [N_CELLS-1:0] gate_hi_i,
  input  logic [N_CELLS-1:0] gate_lo_i,
  output logic [AW-1:0]      arm_volt_o,
  output logic [N_CELLS-1:0] hiz_o,
  output logic               fault_o,
  output logic               step_done_o,
  output logic [AW-1:0]      avg_volt_o,
  output logic               avg_valid_o
);
  localparam int IDXW = (N_CELLS > 1) ? $clog2(N_CELLS) : 1;

  logic                 start, issue, last;
  logic [IDXW-1:0]      idx;
  cell_mode_e           mode;
  logic [N_CELLS-1:0]   hi_q, lo_q;
  logic                 cur_pos_q, cur_zero_q;
  logic signed [VW-1:0] delta_q;
  logic signed [IW+KW-1:0] prod;
  logic signed [AW-1:0] acc;
  logic [N_CELLS-1:0]   hiz_acc;
  logic                 fault_acc;
  logic signed [AW-1:0] avg;

  assign prod = $signed(arm_cur_i) * $signed(dt_over_c_i);

  mmc_step_seq #(.STEP_CYCLES(STEP_CYCLES), .N_CELLS(N_CELLS), .IDXW(IDXW)) u_seq (
    .clk_i, .rst_ni, .run_i,
    .start_o(start), .issue_o(issue), .idx_o(idx), .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q       <= '0;
      lo_q       <= '0;
      cur_pos_q  <= 1'b0;
      cur_zero_q <= 1'b0;
      delta_q    <= '0;
    end else if (start) begin
      hi_q       <= gate_hi_i;
      lo_q       <= gate_lo_i;
      cur_pos_q  <= !arm_cur_i[IW-1] && (arm_cur_i != '0);
      cur_zero_q <= (arm_cur_i == '0);
      delta_q    <= VW'(prod >>> FRAC);
    end
  end

  mmc_cell_decode #(.N_CELLS(N_CELLS), .IDXW(IDXW)) u_dec (
    .hi_i(hi_q), .lo_i(lo_q), .cur_pos_i(cur_pos_q), .cur_zero_i(cur_zero_q),
    .idx_i(idx), .mode_o(mode)
  );

  mmc_cap_pipe #(.N_CELLS(N_CELLS), .VW(VW), .AW(AW), .IDXW(IDXW), .VC_INIT(VC_INIT)) u_pipe (
    .clk_i, .rst_ni, .start_i(start), .issue_i(issue), .idx_i(idx), .mode_i(mode),
    .delta_i(delta_q), .acc_o(acc), .hiz_o(hiz_acc), .fault_o(fault_acc)
  );

  mmc_arm_avg #(.AW(AW), .AVG_STEPS(AVG_STEPS)) u_avg (
    .clk_i, .rst_ni, .tick_i(last), .val_i(acc), .avg_o(avg), .avg_valid_o
  );

  assign avg_volt_o = avg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_volt_o  <= '0;
      hiz_o       <= '0;
      fault_o     <= 1'b0;
      step_done_o <= 1'b0;
    end else begin
      step_done_o <= last;
      if (last) begin
        arm_volt_o <= acc;
        hiz_o      <= hiz_acc;
        fault_o    <= fault_acc;
      end
    end
  end
endmodule

// File: rtl/mmc_arm_eval_chk.sv
module mmc_arm_eval_chk #(
  parameter int AW      = 28,
  parameter int N_CELLS = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [AW-1:0]      arm_volt_o,
  input logic [N_CELLS-1:0] hiz_o,
  input logic               fault_o,
  input logic               step_done_o,
  input logic [AW-1:0]      avg_volt_o,
  input logic               avg_valid_o
);
  // R8
  step_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_done_o |=> !step_done_o);
  // R8
  volt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_done_o |-> $stable(arm_volt_o));
  // R5
  hiz_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_done_o |-> $stable(hiz_o));
  // R6
  fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_done_o |-> $stable(fault_o));
  // R9
  avg_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avg_valid_o |-> step_done_o);
  // R9
  avg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !avg_valid_o |-> $stable(avg_volt_o));
endmodule

bind mmc_arm_eval mmc_arm_eval_chk #(.AW(AW), .N_CELLS(N_CELLS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .arm_volt_o(arm_volt_o), .hiz_o(hiz_o),
  .fault_o(fault_o), .step_done_o(step_done_o), .avg_volt_o(avg_volt_o),
  .avg_valid_o(avg_valid_o)
);

// File: tb/mmc_arm_eval_test.sv
`timescale 1ns/1ps
module mmc_arm_eval_test;
  localparam int N   = 10;
  localparam int AVG = 100;
  localparam int AW  = 24 + $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          run_i = 1'b0;
  logic [15:0]   dt_over_c_i = '0;
  logic [15:0]   arm_cur_i = '0;
  logic [N-1:0]  gate_hi_i = '0, gate_lo_i = '0;
  logic [AW-1:0] arm_volt_o, avg_volt_o;
  logic [N-1:0]  hiz_o;
  logic          fault_o, step_done_o, avg_valid_o;

  int     total = 0, bad = 0, step_no = 0;
  int     vc_m [N];
  longint sum_m = 0;

  always #10 clk = ~clk;

  mmc_arm_eval uut (
    .clk_i(clk), .rst_ni, .run_i, .dt_over_c_i, .arm_cur_i, .gate_hi_i, .gate_lo_i,
    .arm_volt_o, .hiz_o, .fault_o, .step_done_o, .avg_volt_o, .avg_valid_o
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_step(input logic [N-1:0] hi, input logic [N-1:0] lo,
                         input int cur, input int k, input string tag);
    int     delta, cnt;
    longint ev;
    logic [N-1:0] eh;
    logic   ef;
    delta = (cur * k) >>> 12;
    ev = 0; eh = '0; ef = 1'b0;
    for (int i = 0; i < N; i++) begin
      unique case ({hi[i], lo[i]})
        2'b10: begin ev += vc_m[i]; vc_m[i] += delta; end
        2'b01: ;
        2'b11: ef = 1'b1;
        default: begin
          if (cur > 0) begin ev += vc_m[i]; vc_m[i] += delta; end
          else if (cur == 0) eh[i] = 1'b1;
        end
      endcase
    end
    gate_hi_i = hi; gate_lo_i = lo;
    arm_cur_i = 16'(cur); dt_over_c_i = 16'(k);
    run_i = 1'b1;
    @(posedge clk);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 3) begin  // R7: corrupt after sampling
        arm_cur_i = 16'(-cur - 7); dt_over_c_i = 16'h7fff;
        gate_hi_i = ~hi; gate_lo_i = ~lo;
      end
    end while (!step_done_o && cnt < 60);
    step_no++;
    chk({"R8 step length ", tag}, cnt, 25);
    chk({"arm volt ", tag}, longint'($signed(arm_volt_o)), ev);
    chk({"R5 hiz ", tag}, hiz_o, eh);
    chk({"R6 fault ", tag}, fault_o, ef);
    sum_m += ev;
    if (step_no % AVG == 0) begin
      chk("R9 avg valid", avg_valid_o, 1);
      chk("R9 avg value", longint'($signed(avg_volt_o)), sum_m / AVG);
      sum_m = 0;
    end else begin
      chk("R9 avg idle", avg_valid_o, 0);
    end
  endtask

  initial begin
    logic [N-1:0] ones, zeros;
    ones = '1; zeros = '0;
    for (int i = 0; i < N; i++) vc_m[i] = 1000;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10 arm volt", arm_volt_o, 0);
    chk("R10 hiz", hiz_o, 0);
    chk("R10 fault", fault_o, 0);
    chk("R10 done", step_done_o, 0);
    chk("R10 avg", avg_volt_o, 0);
    begin
      int seen = 0;
      arm_cur_i = 16'd50; dt_over_c_i = 16'd4096; gate_hi_i = '1;
      repeat (40) begin @(negedge clk); if (step_done_o) seen++; end
      chk("R11 idle no step", seen, 0);
      chk("R11 idle volt", arm_volt_o, 0);
    end
    do_step(ones, zeros, 100, 4096, "R1 insert");         // reveals 1000 each
    do_step(zeros, ones, 300, 4096, "R2 bypass");
    do_step(zeros, zeros, 200, 2048, "R3 diode charge");
    do_step(zeros, zeros, -250, 4096, "R4 diode block");
    do_step(zeros, zeros, 0, 4096, "R5 float");
    do_step(ones, ones, 400, 4096, "R6 short");
    do_step(ones, zeros, -60, 4096, "R1 R7 reveal");
    for (int s = 0; s < 100; s++) begin
      logic [N-1:0] hi, lo;
      int cur;
      for (int i = 0; i < N; i++) begin
        int g;
        g = (i * 3 + s * 7) % 4;
        hi[i] = g[0];
        lo[i] = g[1];
      end
      case (s % 3)
        0: cur = s * 5 + 40;
        1: cur = -(s * 3 + 20);
        default: cur = 0;
      endcase
      do_step(hi, lo, cur, 4096 + s * 16, "sweep");
    end
    run_i = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule